// File: doc/BRIEF.md
# Flyback Switching Cycle and Fault Supervisor

This block is the control state machine at the heart of an offline flyback LED driver. Its inputs are single-bit comparator flags, already synchronised to the clock: two from the voltage-feedback path that arm and detect the switching valley, two that report a high output level (the regulation level and the overvoltage limit), and three from the current-sense path (peak reached, overcurrent, and sense-resistor short). It drives one gate-enable output for the flyback switch, a shutdown status and a two-bit fault code.

Each switching cycle has an on-time and an off-time. The on-time ends on the peak-current flag, or on a maximum on-time limit if that flag never arrives. The off-time lasts until the feedback has fallen below the valley-mode threshold, which arms valley detection, and a valley is then seen. If no armed valley appears, a timeout starts the next cycle. While the output sits above its regulation level, no new on-time is started. Faults are sorted by their reaction. An overvoltage latches shutdown until reset. An overcurrent, or a sense short found when the on-time limit expires, holds shutdown for a fixed time and then re-initialises all of the logic.

Top module: `flyback_supervisor`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the block returns to its initial off-time wait with `gate_on`=0, `shutdown`=0 and `fault_code`=0 (0 means no fault).
- R2: When `cs_peak` is sampled high during an on-time, `gate_on` is low from the next cycle on.
- R3: Without a peak flag, an on-time lasts exactly MAX_ON cycles of `gate_on` high and then ends.
- R4: `fb_valley` is ignored until `fb_arm` has been sampled high during the current off-time. Once armed, a sampled valley starts the on-time, so `gate_on` is high in the next cycle.
- R5: If no armed valley appears, the on-time starts after VALLEY_TMO off-time cycles. From reset release, the first high `gate_on` is seen in the VALLEY_TMO-th cycle.
- R6: While `fb_reg` is high, no new on-time starts (neither on a valley nor on the timeout), and `fault_code` stays 0. When `fb_reg` falls after the timeout has elapsed, the next cycle starts at once.
- R7: `fb_ovp` sampled high outside shutdown gives `shutdown`=1, `gate_on`=0 and `fault_code`=1 from the next cycle. This holds, whatever the other inputs do, until `rst_n` is asserted.
- R8: `cs_ocp` sampled high outside shutdown gives `shutdown`=1 and `fault_code`=2 for RESTART_HOLD cycles. The block then re-initialises to the off-time wait with `fault_code`=0.
- R9: `cs_short` is judged only in the cycle where the on-time limit expires with no peak. If it is high there, the block sets `fault_code`=3 and follows the same hold-and-restart as R8. At any other time it has no effect.
- R10: When several events fall in one cycle, overvoltage wins over overcurrent, and overcurrent wins over sense short. A peak flag in the same cycle as on-time expiry is a normal turn-off with no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| fb_arm | input | 1 | Feedback below the valley-mode threshold |
| fb_valley | input | 1 | Feedback valley detected |
| fb_reg | input | 1 | Output above the regulation level |
| fb_ovp | input | 1 | Output overvoltage |
| cs_peak | input | 1 | Sense current reached peak limit |
| cs_ocp | input | 1 | Primary overcurrent |
| cs_short | input | 1 | Sense voltage below the short threshold |
| gate_on | output | 1 | Flyback gate enable |
| shutdown | output | 1 | Block held in a fault state |
| fault_code | output | 2 | 0 none, 1 overvoltage, 2 overcurrent, 3 sense short |

## Verification
The costly collision is the on-time limit expiring in the very cycle a peak flag arrives while the short flag is high: the peak must win and no fault may appear. The bench counts on-cycles from the rising gate and places the peak flag exactly in the MAX_ON-th cycle with the short flag held. It then expects a plain off-time. A second collision, overvoltage and overcurrent in one cycle, is provoked directly and must leave code 1 latched. A cycle-by-cycle reference model checks both collisions and a long stretch of pseudo-random flags.

// File: rtl/flyback_sup_pkg.sv
// Shared types for the flyback supervisor: control states and fault codes.
// Assumes fault code values are decoded by software-visible status logic.
package flyback_sup_pkg;
    typedef enum logic [2:0] {
        ST_WAIT    = 3'd0,
        ST_ARMED   = 3'd1,
        ST_ON      = 3'd2,
        ST_LATCH   = 3'd3,
        ST_RESTART = 3'd4
    } sup_state_e;

    typedef enum logic [1:0] {
        FC_NONE  = 2'd0,
        FC_OVP   = 2'd1,
        FC_OCP   = 2'd2,
        FC_SHORT = 2'd3
    } fault_code_e;
endpackage

// File: rtl/fsup_timer.sv
// Saturating phase timer: counts enabled cycles from zero, holds at LIMIT-1.
// Assumes clr is asserted whenever the owning phase is not active, so the
// count is zero in the first cycle of that phase.
module fsup_timer #(
    parameter int LIMIT = 16,
    localparam int W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    // Count phase cycles, saturating at the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (en && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Terminal cycle indicator.
    assign done = (cnt_q == LAST);

    AST_TMR_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && en && !clr) |=> done); // R5
endmodule

// File: rtl/fsup_fault_arb.sv
// Fault priority arbiter: overvoltage over overcurrent over sense short.
// Assumes active is low in any fault state so those states ignore inputs.
module fsup_fault_arb
    import flyback_sup_pkg::*;
(
    input  logic        active,
    input  logic        on_expire,
    input  logic        ovp,
    input  logic        ocp,
    input  logic        short_flag,
    output logic        hit,
    output logic        latch_kind,
    output fault_code_e code
);
    // Pick the highest-priority fault present this cycle.
    always_comb begin
        code = FC_NONE;
        if (active) begin
            if (ovp) begin
                code = FC_OVP;
            end else if (ocp) begin
                code = FC_OCP;
            end else if (on_expire && short_flag) begin
                code = FC_SHORT;
            end
        end
    end

    // Any fault, and whether it is the latching kind.
    assign hit        = (code != FC_NONE);
    assign latch_kind = (code == FC_OVP);
endmodule

// File: rtl/flyback_supervisor.sv
// Flyback switching-cycle controller with fault supervision.
// Sequences on-time (ended by peak flag or MAX_ON limit) and off-time (ended
// by an armed valley or VALLEY_TMO timeout), and sorts faults into a latched
// shutdown or a timed hold followed by a full logic restart.
// Assumes all comparator flags are already synchronous to clk.
module flyback_supervisor
    import flyback_sup_pkg::*;
#(
    parameter int MAX_ON       = 16,
    parameter int VALLEY_TMO   = 24,
    parameter int RESTART_HOLD = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fb_arm,
    input  logic       fb_valley,
    input  logic       fb_reg,
    input  logic       fb_ovp,
    input  logic       cs_peak,
    input  logic       cs_ocp,
    input  logic       cs_short,
    output logic       gate_on,
    output logic       shutdown,
    output logic [1:0] fault_code
);
    sup_state_e  state_q, state_d;
    fault_code_e code_q;
    fault_code_e arb_code;
    logic        on_phase, off_phase, rs_phase;
    logic        on_done, off_done, rs_done;
    logic        on_expire, start_ok, fault_hit, fault_latch;

    // Phase decode from the state register.
    assign on_phase  = (state_q == ST_ON);
    assign off_phase = (state_q == ST_WAIT) || (state_q == ST_ARMED);
    assign rs_phase  = (state_q == ST_RESTART);

    fsup_timer #(.LIMIT(MAX_ON)) u_on_tmr (
        .clk(clk), .rst_n(rst_n), .clr(!on_phase), .en(on_phase), .done(on_done)
    );
    fsup_timer #(.LIMIT(VALLEY_TMO)) u_off_tmr (
        .clk(clk), .rst_n(rst_n), .clr(!off_phase), .en(off_phase), .done(off_done)
    );
    fsup_timer #(.LIMIT(RESTART_HOLD)) u_rs_tmr (
        .clk(clk), .rst_n(rst_n), .clr(!rs_phase), .en(rs_phase), .done(rs_done)
    );

    // On-time limit reached with no peak flag.
    assign on_expire = on_phase && on_done && !cs_peak;
    // Next cycle may begin: regulation clear and valley or timeout.
    assign start_ok  = !fb_reg && (off_done || (state_q == ST_ARMED && fb_valley));

    fsup_fault_arb u_arb (
        .active    (on_phase || off_phase),
        .on_expire (on_expire),
        .ovp       (fb_ovp),
        .ocp       (cs_ocp),
        .short_flag(cs_short),
        .hit       (fault_hit),
        .latch_kind(fault_latch),
        .code      (arb_code)
    );

    // Next-state selection; faults override normal sequencing.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:    if (start_ok) state_d = ST_ON;
                        else if (fb_arm) state_d = ST_ARMED;
            ST_ARMED:   if (start_ok) state_d = ST_ON;
            ST_ON:      if (cs_peak || on_expire) state_d = ST_WAIT;
            ST_LATCH:   state_d = ST_LATCH;
            ST_RESTART: if (rs_done) state_d = ST_WAIT;
            default:    state_d = ST_WAIT;
        endcase
        if (fault_hit) begin
            state_d = fault_latch ? ST_LATCH : ST_RESTART;
        end
    end

    // State register with synchronous power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // Fault code capture on entry, cleared when a restart completes.
    always_ff @(posedge clk) begin
        if (!rst_n)                 code_q <= FC_NONE;
        else if (fault_hit)         code_q <= arb_code;
        else if (rs_phase && rs_done) code_q <= FC_NONE;
    end

    // Output decode.
    assign gate_on    = on_phase;
    assign shutdown   = (state_q == ST_LATCH) || rs_phase;
    assign fault_code = code_q;

    AST_PEAK_ENDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (on_phase && cs_peak) |=> !gate_on); // R2
    AST_ON_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (on_phase && on_done) |=> !gate_on); // R3
    AST_DISARMED_VALLEY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && fb_valley && !off_done) |=> !gate_on); // R4
    AST_REG_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (off_phase && fb_reg) |=> !gate_on); // R6
    AST_OVP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCH) |=> (shutdown && $stable(fault_code))); // R7
    AST_SD_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> !gate_on); // R7
    AST_RUN_CODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !shutdown |-> (fault_code == 2'd0)); // R8
endmodule

// File: tb/flyback_supervisor_tb_top.sv
`timescale 1ns/1ps
module flyback_supervisor_tb_top;
    localparam int MAX_ON = 16;
    localparam int TMO    = 24;
    localparam int HOLD   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fb_arm = 0, fb_valley = 0, fb_reg = 0, fb_ovp = 0;
    logic cs_peak = 0, cs_ocp = 0, cs_short = 0;
    logic gate_on, shutdown;
    logic [1:0] fault_code;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    flyback_supervisor #(.MAX_ON(MAX_ON), .VALLEY_TMO(TMO), .RESTART_HOLD(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .fb_arm(fb_arm), .fb_valley(fb_valley),
        .fb_reg(fb_reg), .fb_ovp(fb_ovp), .cs_peak(cs_peak), .cs_ocp(cs_ocp),
        .cs_short(cs_short), .gate_on(gate_on), .shutdown(shutdown),
        .fault_code(fault_code)
    );

    // Behavioural reference: phase 0 wait, 1 armed, 2 on, 3 latched, 4 restart.
    int ph = 0, on_len = 0, off_len = 0, rs_len = 0, m_code = 0;
    bit m_valid = 0;

    always @(posedge clk) begin
        m_valid = 1;
        if (!rst_n) begin
            ph = 0; on_len = 0; off_len = 0; rs_len = 0; m_code = 0;
        end else begin
            case (ph)
                0, 1: begin
                    off_len++;
                    if (fb_ovp) begin ph = 3; m_code = 1; end
                    else if (cs_ocp) begin ph = 4; m_code = 2; rs_len = 0; end
                    else if (!fb_reg && (off_len >= TMO || (ph == 1 && fb_valley))) begin
                        ph = 2; on_len = 0;
                    end else if (ph == 0 && fb_arm) ph = 1;
                end
                2: begin
                    on_len++;
                    if (fb_ovp) begin ph = 3; m_code = 1; end
                    else if (cs_ocp) begin ph = 4; m_code = 2; rs_len = 0; end
                    else if (cs_peak) begin ph = 0; off_len = 0; end
                    else if (on_len >= MAX_ON) begin
                        if (cs_short) begin ph = 4; m_code = 3; rs_len = 0; end
                        else begin ph = 0; off_len = 0; end
                    end
                end
                4: begin
                    rs_len++;
                    if (rs_len >= HOLD) begin ph = 0; off_len = 0; m_code = 0; end
                end
                default: ;
            endcase
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare outputs with the reference on every cycle, away from the edge.
    always @(negedge clk) begin
        if (m_valid && !finished) begin
            chk("R2 model gate_on", int'(gate_on), int'(ph == 2));
            chk("R7 model shutdown", int'(shutdown), int'(ph >= 3));
            chk("R10 model fault_code", int'(fault_code), m_code);
        end
    end

    task automatic wait_gate(logic lvl);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (gate_on == lvl) return;
        end
        chk("wait_gate timeout", 0, 1);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R1 gate after reset", int'(gate_on), 0);
        chk("R1 shutdown after reset", int'(shutdown), 0);
        chk("R1 code after reset", int'(fault_code), 0);
        rst_n = 1'b1;

        // R5: timeout start from reset release.
        n = 0;
        do begin @(negedge clk); n++; end while (!gate_on && n < 200);
        chk("R5 first on-time delay", n, TMO);
        // R3: on-time length without peak.
        n = 1;
        do begin @(negedge clk); if (gate_on) n++; end while (gate_on);
        chk("R3 on-time length", n, MAX_ON);

        // R2: peak ends the on-time next cycle.
        wait_gate(1);
        @(negedge clk); @(negedge clk);
        cs_peak = 1;
        @(negedge clk); cs_peak = 0;
        chk("R2 gate after peak", int'(gate_on), 0);

        // R4: valley ignored before arming, taken after arming.
        fb_valley = 1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R4 valley before arm", int'(gate_on), 0);
        end
        fb_valley = 0; fb_arm = 1;
        @(negedge clk); fb_arm = 0; fb_valley = 1;
        @(negedge clk); fb_valley = 0;
        chk("R4 armed valley starts", int'(gate_on), 1);

        // R6: regulation blocks starts and raises no code.
        cs_peak = 1;
        @(negedge clk); cs_peak = 0; fb_reg = 1;
        for (int i = 0; i < TMO + 10; i++) begin
            @(negedge clk);
            chk("R6 no start in regulation", int'(gate_on), 0);
            chk("R6 no code in regulation", int'(fault_code), 0);
        end
        fb_reg = 0;
        @(negedge clk);
        chk("R6 start after regulation", int'(gate_on), 1);

        // R9: short flag ignored when a peak ends the on-time.
        cs_short = 1;
        @(negedge clk); @(negedge clk); cs_peak = 1;
        @(negedge clk); cs_peak = 0; cs_short = 0;
        chk("R9 short ignored with peak", int'(fault_code), 0);
        chk("R9 no shutdown with peak", int'(shutdown), 0);

        // R9: short judged at on-time expiry, then restart (R8 timing).
        wait_gate(1);
        cs_short = 1;
        wait_gate(0);
        cs_short = 0;
        chk("R9 short code", int'(fault_code), 3);
        chk("R9 short shutdown", int'(shutdown), 1);
        n = 1;
        do begin @(negedge clk); if (shutdown) n++; end while (shutdown);
        chk("R8 restart hold length", n, HOLD);
        chk("R8 code cleared after restart", int'(fault_code), 0);

        // R8: overcurrent during off-time.
        @(negedge clk); cs_ocp = 1;
        @(negedge clk); cs_ocp = 0;
        chk("R8 ocp code", int'(fault_code), 2);
        chk("R8 ocp shutdown", int'(shutdown), 1);
        repeat (HOLD) @(negedge clk);
        chk("R8 ocp released", int'(shutdown), 0);
        chk("R8 ocp code cleared", int'(fault_code), 0);

        // R10: peak in the expiry cycle with short high is a normal end.
        wait_gate(1);
        cs_short = 1;
        repeat (MAX_ON - 1) @(negedge clk);
        cs_peak = 1;
        @(negedge clk); cs_peak = 0; cs_short = 0;
        chk("R10 peak at expiry gate", int'(gate_on), 0);
        chk("R10 peak at expiry no fault", int'(fault_code), 0);

        // R10: overvoltage beats overcurrent.
        fb_ovp = 1; cs_ocp = 1;
        @(negedge clk); fb_ovp = 0; cs_ocp = 0;
        chk("R10 ovp priority code", int'(fault_code), 1);

        // R7: latched shutdown ignores all inputs.
        for (int i = 0; i < 40; i++) begin
            cs_peak = i[0]; fb_valley = i[1]; fb_arm = i[2]; cs_ocp = i[3]; cs_short = i[0];
            @(negedge clk);
            chk("R7 latched shutdown", int'(shutdown), 1);
            chk("R7 latched code", int'(fault_code), 1);
            chk("R7 latched gate", int'(gate_on), 0);
        end
        {cs_peak, fb_valley, fb_arm, cs_ocp, cs_short} = '0;
        rst_n = 0;
        @(negedge clk);
        chk("R1 reset clears latch", int'(shutdown), 0);
        chk("R1 reset clears code", int'(fault_code), 0);
        rst_n = 1;

        // Mixed pseudo-random flags against the reference model.
        for (int i = 0; i < 3000; i++) begin
            cs_peak   = ($urandom % 8) == 0;
            fb_arm    = ($urandom % 16) == 0;
            fb_valley = ($urandom % 4) == 0;
            fb_reg    = ($urandom % 16) == 0;
            cs_ocp    = ($urandom % 400) == 0;
            cs_short  = ($urandom % 2) == 0;
            @(negedge clk);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule